// File: doc/BRIEF.md
# Exact-Count Unaligned IO Bus Cycle Generator

This block sits between a processor's unaligned-access path and a 16-bit IO bus. It takes one IO-space access, given as a byte address, a byte length of 1, 2 or 3, a direction and right-aligned write data. It then issues the smallest correct series of bus cycles for that access, one at a time, over a request/acknowledge handshake. The bus has three cycle types: word read, word write and byte write.

IO reads can have side effects, so the block never issues a speculative or surplus cycle. It also never turns a byte write into a word read-modify-write. For reads, the returned words are packed into a 32-bit result laid out the way an aligned IO read would return it. A single done pulse closes each access.

The caller presents a request while the block is not busy. The caller then waits for `done`, or for `err` if the length is not legal.

Top module: `ioq_exact_cycler`

## Requirements
- R1: After reset, `bus_req`, `done`, `err` and `busy` are all low.
- R2: A read whose length plus address bit 0 is at most 2 issues exactly one word read (`bus_we`=0) at the access address. The word lands in `rd_data[31:16]` when address bit 1 is 1, and in `rd_data[15:0]` otherwise. The other half is zero.
- R3: Any other read issues two word reads, first at the address and then at address+2. `rd_data` is {second word, first word}.
- R4: A 1-byte write is one byte-write cycle (`bus_we`=1, `bus_byte`=1) at the address. `bus_wdata` carries data bits 7:0, with the upper byte zero.
- R5: A 2-byte write at an even address is one word write (`bus_we`=1, `bus_byte`=0) carrying data bits 15:0. At an odd address it is two byte writes: bits 7:0 at the address, then bits 15:8 at address+1.
- R6: A 3-byte write at an odd address is a byte write of bits 7:0 at the address, followed by a word write of bits 23:8 at address+1.
- R7: A 3-byte write at an even address is a word write of bits 15:0 at the address, followed by a byte write of bits 23:16 at address+2.
- R8: While `bus_req` is high without `bus_ack`, the address, type and data hold steady. The next cycle is requested, or `done` is raised, in the clock cycle right after the acknowledge.
- R9: `done` is a single-cycle pulse that follows the final acknowledge. For a read, `rd_data` is valid while `done` is high.
- R10: A request with a length of 0 or 4 to 7 raises `err` for one cycle. It issues no bus cycle and no `done`.
- R11: A request presented while `busy` is high is ignored and does not disturb the access in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request, taken when `busy` is low |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address of the access |
| req_len | input | 3 | Length in bytes (1 to 3 legal) |
| req_wdata | input | 24 | Right-aligned write data |
| busy | output | 1 | Access in progress |
| bus_req | output | 1 | Bus cycle request |
| bus_we | output | 1 | Cycle is a write |
| bus_byte | output | 1 | Write is a byte write |
| bus_addr | output | ADDR_W | Cycle byte address |
| bus_wdata | output | 16 | Cycle write data, byte writes in bits 7:0 |
| bus_ack | input | 1 | Cycle acknowledge |
| bus_rdata | input | 16 | Read word, valid with `bus_ack` |
| done | output | 1 | Access complete pulse |
| err | output | 1 | Illegal length pulse |
| rd_data | output | 32 | Assembled read result |

## Verification
The embedded properties assume that `bus_ack` is raised only while `bus_req` is high, and only once per cycle. They also assume that `bus_rdata` is valid in the same clock as that acknowledge. The bench's bus responder meets this. It looks at `bus_req` away from the clock edge and only then drives an acknowledge, with the read word taken from a fixed function of `bus_addr`. It holds the acknowledge off for zero, one or two cycles to exercise the hold rule. A second request injected mid-access checks that requests made while busy are dropped. Illegal lengths are sent only while the block is idle.

// File: rtl/qcyc_pkg.sv
package qcyc_pkg;

    localparam int BUS_W   = 16;
    localparam int RES_W   = 32;
    localparam int WDATA_W = 24;
    localparam int LEN_W   = 3;
    localparam int OFFS_W  = 3;

    typedef enum logic [1:0] {
        CK_RD_WORD = 2'd0,
        CK_WR_WORD = 2'd1,
        CK_WR_BYTE = 2'd2
    } cyc_kind_e;

    typedef struct packed {
        cyc_kind_e          kind;
        logic [OFFS_W-1:0]  offs;   // byte offset from access address
        logic [BUS_W-1:0]   data;
    } cyc_desc_t;

    typedef struct packed {
        logic               two;     // second cycle present
        logic               hi_lane; // single read lands in upper half
        cyc_desc_t [1:0]    cyc;
    } plan_t;

    function automatic logic len_legal(input logic [LEN_W-1:0] len);
        return (len == 3'd1) || (len == 3'd2) || (len == 3'd3);
    endfunction

    function automatic cyc_desc_t mk(input cyc_kind_e k, input logic [OFFS_W-1:0] o,
                                     input logic [BUS_W-1:0] d);
        cyc_desc_t c;
        c.kind = k;
        c.offs = o;
        c.data = d;
        return c;
    endfunction

    // Chooses the exact cycle sequence for one access.
    function automatic plan_t build_plan(input logic we, input logic [1:0] lo,
                                         input logic [LEN_W-1:0] len,
                                         input logic [WDATA_W-1:0] d);
        plan_t p;
        p = '0;
        if (!we) begin
            p.two     = ({1'b0, len} + {3'b0, lo[0]}) > 4'd2;
            p.hi_lane = lo[1] & ~p.two;
            p.cyc[0]  = mk(CK_RD_WORD, 3'd0, '0);
            p.cyc[1]  = mk(CK_RD_WORD, 3'd2, '0);
        end else begin
            unique case (len)
                3'd2: begin
                    if (lo[0]) begin
                        p.two    = 1'b1;
                        p.cyc[0] = mk(CK_WR_BYTE, 3'd0, {8'h00, d[7:0]});
                        p.cyc[1] = mk(CK_WR_BYTE, 3'd1, {8'h00, d[15:8]});
                    end else begin
                        p.cyc[0] = mk(CK_WR_WORD, 3'd0, d[15:0]);
                    end
                end
                3'd3: begin
                    p.two = 1'b1;
                    if (lo[0]) begin
                        p.cyc[0] = mk(CK_WR_BYTE, 3'd0, {8'h00, d[7:0]});
                        p.cyc[1] = mk(CK_WR_WORD, 3'd1, d[23:8]);
                    end else begin
                        p.cyc[0] = mk(CK_WR_WORD, 3'd0, d[15:0]);
                        p.cyc[1] = mk(CK_WR_BYTE, 3'd2, {8'h00, d[23:16]});
                    end
                end
                default: begin
                    p.cyc[0] = mk(CK_WR_BYTE, 3'd0, {8'h00, d[7:0]});
                end
            endcase
        end
        return p;
    endfunction

endpackage

// File: rtl/qcyc_planner.sv
module qcyc_planner
    import qcyc_pkg::*;
(
    input  logic               we,
    input  logic [1:0]         addr_lo,
    input  logic [LEN_W-1:0]   len,
    input  logic [WDATA_W-1:0] wdata,
    output logic               legal,
    output plan_t              plan
);
    always_comb begin
        legal = len_legal(len);
        plan  = build_plan(we, addr_lo, len, wdata);
    end
endmodule

// File: rtl/qcyc_sequencer.sv
module qcyc_sequencer
    import qcyc_pkg::*;
#(
    parameter int ADDR_W = 22
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  plan_t             plan_in,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              bus_ack,
    output logic              bus_req,
    output logic              bus_we,
    output logic              bus_byte,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [BUS_W-1:0]  bus_wdata,
    output logic              busy,
    output logic              fire,
    output logic              last_fire,
    output logic              first_of_two,
    output logic              two,
    output logic              hi_lane
);
    typedef enum logic {S_IDLE = 1'b0, S_RUN = 1'b1} st_e;

    st_e               st_q;
    plan_t             plan_q;
    logic [ADDR_W-1:0] addr_q;
    logic              idx_q;
    cyc_desc_t         cur;

    always_comb begin
        cur          = plan_q.cyc[idx_q];
        bus_req      = (st_q == S_RUN);
        busy         = (st_q == S_RUN);
        bus_we       = (cur.kind != CK_RD_WORD);
        bus_byte     = (cur.kind == CK_WR_BYTE);
        bus_addr     = addr_q + ADDR_W'(cur.offs);
        bus_wdata    = cur.data;
        fire         = bus_req & bus_ack;
        last_fire    = fire & (idx_q == plan_q.two);
        first_of_two = fire & plan_q.two & ~idx_q;
        two          = plan_q.two;
        hi_lane      = plan_q.hi_lane;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= S_IDLE;
            plan_q <= '0;
            addr_q <= '0;
            idx_q  <= 1'b0;
        end else if (st_q == S_IDLE) begin
            if (load) begin
                st_q   <= S_RUN;
                plan_q <= plan_in;
                addr_q <= addr_in;
                idx_q  <= 1'b0;
            end
        end else if (fire) begin
            if (last_fire) st_q  <= S_IDLE;
            else           idx_q <= 1'b1;
        end
    end

    // R8: request and its fields hold until acknowledged
    p_hold_until_ack_r8: assert property (@(posedge clk) disable iff (rst)
        bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_we)
                                && $stable(bus_byte) && $stable(bus_wdata));

    // R5: a byte cycle is always a write, never a read-modify-write
    p_byte_is_write_r5: assert property (@(posedge clk) disable iff (rst)
        bus_req && bus_byte |-> bus_we);

    // R3: never beyond the second cycle of an access
    p_idx_bound_r3: assert property (@(posedge clk) disable iff (rst)
        bus_req && idx_q |-> plan_q.two);
endmodule

// File: rtl/qcyc_rd_assembler.sv
module qcyc_rd_assembler
    import qcyc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             first_of_two,
    input  logic             last_fire,
    input  logic             two,
    input  logic             hi_lane,
    input  logic [BUS_W-1:0] bus_rdata,
    output logic             done,
    output logic [RES_W-1:0] rd_data
);
    logic [BUS_W-1:0] lo_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q    <= '0;
            done    <= 1'b0;
            rd_data <= '0;
        end else begin
            done <= last_fire;
            if (first_of_two) lo_q <= bus_rdata;
            if (last_fire) begin
                if (two)          rd_data <= {bus_rdata, lo_q};
                else if (hi_lane) rd_data <= {bus_rdata, {BUS_W{1'b0}}};
                else              rd_data <= {{BUS_W{1'b0}}, bus_rdata};
            end
        end
    end

    // R9: done lasts exactly one cycle
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9: done only after a final acknowledge
    p_done_after_ack_r9: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(last_fire));
endmodule

// File: rtl/ioq_exact_cycler.sv
module ioq_exact_cycler
    import qcyc_pkg::*;
#(
    parameter int ADDR_W = 22
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic               req_we,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [2:0]         req_len,
    input  logic [23:0]        req_wdata,
    output logic               busy,
    output logic               bus_req,
    output logic               bus_we,
    output logic               bus_byte,
    output logic [ADDR_W-1:0]  bus_addr,
    output logic [15:0]        bus_wdata,
    input  logic               bus_ack,
    input  logic [15:0]        bus_rdata,
    output logic               done,
    output logic               err,
    output logic [31:0]        rd_data
);
    logic  legal, accept, load;
    plan_t plan;
    logic  fire, last_fire, first_of_two, two, hi_lane;

    qcyc_planner u_plan (
        .we      (req_we),
        .addr_lo (req_addr[1:0]),
        .len     (req_len),
        .wdata   (req_wdata),
        .legal   (legal),
        .plan    (plan)
    );

    assign accept = req_valid & ~busy;
    assign load   = accept & legal;

    always_ff @(posedge clk) begin
        if (rst) err <= 1'b0;
        else     err <= accept & ~legal;
    end

    qcyc_sequencer #(.ADDR_W(ADDR_W)) u_seq (
        .clk          (clk),
        .rst          (rst),
        .load         (load),
        .plan_in      (plan),
        .addr_in      (req_addr),
        .bus_ack      (bus_ack),
        .bus_req      (bus_req),
        .bus_we       (bus_we),
        .bus_byte     (bus_byte),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .busy         (busy),
        .fire         (fire),
        .last_fire    (last_fire),
        .first_of_two (first_of_two),
        .two          (two),
        .hi_lane      (hi_lane)
    );

    qcyc_rd_assembler u_asm (
        .clk          (clk),
        .rst          (rst),
        .first_of_two (first_of_two),
        .last_fire    (last_fire),
        .two          (two),
        .hi_lane      (hi_lane),
        .bus_rdata    (bus_rdata),
        .done         (done),
        .rd_data      (rd_data)
    );

    // R10: a rejected request leaves the bus idle and gives no done
    p_err_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        err |-> !bus_req && !done);

    // R1: outputs idle in the cycle after reset
    p_reset_idle_r1: assert property (@(posedge clk)
        $past(rst) |-> !bus_req && !done && !err);

    // R8: an acknowledge never leaves a dead cycle mid-access
    p_no_gap_r8: assert property (@(posedge clk) disable iff (rst)
        fire && !last_fire |=> bus_req);
endmodule

// File: tb/ioq_exact_cycler_test.sv
`timescale 1ns/1ps
module ioq_exact_cycler_test;
    localparam int AW = 22;
    localparam logic [AW-1:0] BASE = 22'h123450;
    localparam logic [23:0]   WD   = 24'hC3B2A1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0, req_we = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [2:0]  req_len = '0;
    logic [23:0] req_wdata = '0;
    logic busy, bus_req, bus_we, bus_byte, done, err;
    logic [AW-1:0] bus_addr;
    logic [15:0] bus_wdata;
    logic bus_ack = 1'b0;
    logic [15:0] bus_rdata = '0;
    logic [31:0] rd_data;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    ioq_exact_cycler #(.ADDR_W(AW)) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_we(req_we),
        .req_addr(req_addr), .req_len(req_len), .req_wdata(req_wdata),
        .busy(busy), .bus_req(bus_req), .bus_we(bus_we), .bus_byte(bus_byte),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
        .bus_rdata(bus_rdata), .done(done), .err(err), .rd_data(rd_data)
    );

    // kind: 0 word read, 1 word write, 2 byte write; offsets from access address
    typedef struct packed {
        logic       we;
        logic [2:0] len;
        logic [1:0] lo;
        logic [1:0] n;
        logic [1:0] k0; logic [2:0] o0; logic [15:0] d0;
        logic [1:0] k1; logic [2:0] o1; logic [15:0] d1;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{1'b0,3'd1,2'd0,2'd1,2'd0,3'd0,16'h0,2'd0,3'd0,16'h0},
        '{1'b0,3'd1,2'd3,2'd1,2'd0,3'd0,16'h0,2'd0,3'd0,16'h0},
        '{1'b0,3'd2,2'd0,2'd1,2'd0,3'd0,16'h0,2'd0,3'd0,16'h0},
        '{1'b0,3'd2,2'd2,2'd1,2'd0,3'd0,16'h0,2'd0,3'd0,16'h0},
        '{1'b0,3'd2,2'd1,2'd2,2'd0,3'd0,16'h0,2'd0,3'd2,16'h0},
        '{1'b0,3'd3,2'd0,2'd2,2'd0,3'd0,16'h0,2'd0,3'd2,16'h0},
        '{1'b0,3'd3,2'd1,2'd2,2'd0,3'd0,16'h0,2'd0,3'd2,16'h0},
        '{1'b0,3'd2,2'd3,2'd2,2'd0,3'd0,16'h0,2'd0,3'd2,16'h0},
        '{1'b1,3'd1,2'd1,2'd1,2'd2,3'd0,16'h00A1,2'd0,3'd0,16'h0},
        '{1'b1,3'd1,2'd2,2'd1,2'd2,3'd0,16'h00A1,2'd0,3'd0,16'h0},
        '{1'b1,3'd2,2'd0,2'd1,2'd1,3'd0,16'hB2A1,2'd0,3'd0,16'h0},
        '{1'b1,3'd2,2'd2,2'd1,2'd1,3'd0,16'hB2A1,2'd0,3'd0,16'h0},
        '{1'b1,3'd2,2'd3,2'd2,2'd2,3'd0,16'h00A1,2'd2,3'd1,16'h00B2},
        '{1'b1,3'd3,2'd1,2'd2,2'd2,3'd0,16'h00A1,2'd1,3'd1,16'hC3B2},
        '{1'b1,3'd3,2'd0,2'd2,2'd1,3'd0,16'hB2A1,2'd2,3'd2,16'h00C3},
        '{1'b1,3'd3,2'd3,2'd2,2'd2,3'd0,16'h00A1,2'd1,3'd1,16'hC3B2}
    };

    function automatic logic [15:0] rmodel(input logic [AW-1:0] a);
        return {a[7:0] ^ 8'h5A, a[7:0] + 8'h11};
    endfunction

    function automatic string tag_of(input vec_t v);
        if (!v.we) return (v.n == 2'd1) ? "R2" : "R3";
        if (v.len == 3'd1) return "R4";
        if (v.len == 3'd2) return "R5";
        return v.lo[0] ? "R6" : "R7";
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // recorded cycles
    logic [AW-1:0] ra [4];
    logic          rw [4];
    logic          rb [4];
    logic [15:0]   rdw [4];
    int            ncyc, ndone, nerr, nstab, ngap;
    logic [31:0]   got;

    task automatic run_access(input logic we, input logic [AW-1:0] a, input logic [2:0] len,
                              input int lat, input bit poke);
        bit in_cyc = 0, acked = 0;
        int waitc = 0;
        ncyc = 0; ndone = 0; nerr = 0; nstab = 0; ngap = 0; got = '0;
        @(negedge clk);
        req_valid = 1'b1; req_we = we; req_addr = a; req_len = len; req_wdata = WD;
        for (int t = 0; t < 20; t++) begin
            @(negedge clk);
            if (poke && t == 1) begin
                req_valid = 1'b1; req_we = ~we; req_addr = a + 22'h40; req_len = 3'd1;
            end else begin
                req_valid = 1'b0;
            end
            if (done) begin ndone++; got = rd_data; end
            if (err) nerr++;
            if (acked && !bus_req && !done) ngap++;
            if (bus_req) begin
                if (!in_cyc) begin
                    if (ncyc < 4) begin
                        ra[ncyc] = bus_addr; rw[ncyc] = bus_we;
                        rb[ncyc] = bus_byte; rdw[ncyc] = bus_wdata;
                    end
                    in_cyc = 1; waitc = 0;
                end else if (ncyc < 4 && (bus_addr != ra[ncyc] || bus_we != rw[ncyc] ||
                         bus_byte != rb[ncyc] || bus_wdata != rdw[ncyc])) begin
                    nstab++;
                end
                if (waitc >= lat) begin
                    bus_ack = 1'b1; bus_rdata = rmodel(bus_addr);
                    in_cyc = 0; ncyc++; acked = 1;
                end else begin
                    bus_ack = 1'b0; waitc++; acked = 0;
                end
            end else begin
                bus_ack = 1'b0; bus_rdata = 16'h0; acked = 0;
            end
        end
        req_valid = 1'b0; bus_ack = 1'b0;
    endtask

    task automatic check_vec(input vec_t v, input int lat, input bit poke);
        logic [AW-1:0] a;
        string tg;
        logic [15:0] w0, w1;
        logic [31:0] exp;
        a  = BASE + AW'(v.lo);
        tg = tag_of(v);
        run_access(v.we, a, v.len, lat, poke);
        chk(ncyc == int'(v.n), poke ? "R11" : tg, "cycle count", ncyc, v.n);
        for (int c = 0; c < 2; c++) begin
            logic [1:0] k; logic [2:0] o; logic [15:0] d;
            if (c < int'(v.n) && c < ncyc) begin
                k = (c == 0) ? v.k0 : v.k1;
                o = (c == 0) ? v.o0 : v.o1;
                d = (c == 0) ? v.d0 : v.d1;
                chk(ra[c] == a + AW'(o), tg, "cycle address", 32'(ra[c]), 32'(a + AW'(o)));
                chk({rw[c], rb[c]} == {k != 2'd0, k == 2'd2}, tg, "cycle type",
                    {30'b0, rw[c], rb[c]}, {30'b0, k != 2'd0, k == 2'd2});
                if (v.we) chk(rdw[c] == d, tg, "write data", 32'(rdw[c]), 32'(d));
            end
        end
        chk(ndone == 1, "R9", "done pulses", ndone, 1);
        chk(nstab == 0 && ngap == 0, "R8", "hold/gap violations", nstab + ngap, 0);
        chk(nerr == 0, "R10", "err on legal length", nerr, 0);
        if (!v.we) begin
            w0 = rmodel(a); w1 = rmodel(a + 22'd2);
            if (v.n == 2'd2)  exp = {w1, w0};
            else if (v.lo[1]) exp = {w0, 16'h0};
            else              exp = {16'h0, w0};
            chk(got == exp, tg, "read result", got, exp);
        end
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(!bus_req && !done && !err && !busy, "R1", "idle after reset",
            {28'b0, bus_req, done, err, busy}, 0);

        // table walk, varying acknowledge latency
        for (int i = 0; i < NV; i++) check_vec(VECS[i], i % 3, 1'b0);

        // R11: requests while busy are ignored (two-cycle read and write)
        check_vec(VECS[5], 2, 1'b1);
        check_vec(VECS[13], 1, 1'b1);

        // R10: illegal lengths
        foreach (VECS[i]) begin end
        for (int j = 0; j < 3; j++) begin
            logic [2:0] bl;
            bl = (j == 0) ? 3'd0 : (j == 1) ? 3'd4 : 3'd7;
            run_access(j[0], BASE, bl, 0, 1'b0);
            chk(nerr == 1, "R10", "err pulses", nerr, 1);
            chk(ncyc == 0, "R10", "bus cycles on illegal length", ncyc, 0);
            chk(ndone == 0, "R10", "done on illegal length", ndone, 0);
        end

        // R1: reset mid-access returns to idle
        @(negedge clk);
        req_valid = 1'b1; req_we = 1'b0; req_addr = BASE; req_len = 3'd3;
        @(negedge clk);
        req_valid = 1'b0; rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(!bus_req && !done && !busy, "R1", "idle after mid-access reset",
            {29'b0, bus_req, done, busy}, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule